// File: doc/BRIEF.md
# Delegable Power Domain Controller

This block switches the cores of several power domains on and off under host command. Domain code 0 is the shared cache (L2) domain; codes 1 and up are compute domains such as tiler, shader or stack. Each domain has up to 64 cores, and a static present mask says which cores exist. The host writes a core mask to the argument register, then writes a command word. The controller moves the selected cores through an in-transition phase of a fixed number of cycles before it updates their ready bits.

The host can hand a compute domain to an embedded controller (delegate) and later take it back (retract). While a domain is delegated, the host may not power its cores. Commands that break these ownership rules raise a not-allowed interrupt, and undecodable commands raise an invalid interrupt. Neither changes any state. The embedded controller is a stub: it acknowledges a retraction through one input pin. A soft reset, gated by an allow input, drops all cores and all delegations.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: Register word addresses are: 0 argument (read/write), 1 command (write), 2 status, 3 interrupt raw, 4 interrupt clear (write), 5 interrupt mask (read/write), and for domain d, 16+4d present, 17+4d ready, 18+4d in-transition. Status bit d is "host-allowed" for domain d, bit 8+d is "delegated", bit 16 is retract pending, bit 17 mirrors soft_rst_ok_i and bit 18 is reset in progress. After reset all ready and in-transition masks are zero, every domain is allowed and none is delegated, and raw and mask are zero.
- R2: The command word carries the opcode in bits [3:0] and the domain code in bits [7:4]. The opcodes are 1 power up, 2 power down, 3 delegate, 4 retract, 5 soft reset and 6 inspect. Power up sets the ready bits of the argument-masked present cores exactly TRANS_CYC clock edges after the command write.
- R3: Power down clears the ready bits of the masked present cores TRANS_CYC edges after the command write, and leaves the other cores alone.
- R4: From the command edge until completion, the in-transition mask holds exactly the masked present cores that change state, and it returns to zero on completion. Ready and in-transition bits never include cores that are not present.
- R5: A completion sets interrupt bit 0 (single change). Bit 1 (all changed) is set one edge after every domain's in-transition mask has become zero.
- R6: A delegate command to an idle, host-owned compute domain clears its allowed flag, sets its delegated flag and sets interrupt bit 2.
- R7: A retract command to a delegated domain sets retract pending, which stays set until ec_yield_i is sampled high. At that edge the domain returns to allowed, not delegated, and interrupt bits 4 and 2 are set.
- R8: Delegate or retract aimed at domain 0 sets interrupt bit 6 (not allowed) and changes no flag.
- R9: A power command to a delegated domain, or to a domain still in transition, sets interrupt bit 6 and leaves its ready mask unchanged.
- R10: A domain code of NUM_DOM or more, or an unknown opcode, sets interrupt bit 7 (invalid) and changes no state.
- R11: Soft reset with soft_rst_ok_i low sets bit 6. With soft_rst_ok_i high it sets status bit 18. After RST_CYC edges it clears every ready mask and every delegation and sets interrupt bit 3.
- R12: Inspect aimed at a valid domain sets interrupt bit 5.
- R13: Writing ones to the clear register clears those raw bits. Raw bits otherwise stay set, and irq_o is high exactly when some raw bit is also set in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address for reads and writes |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, combinational on reg_addr_i |
| present_i | input | NUM_DOM*CORES | Per-domain present core masks, domain d at bits d*CORES |
| ec_yield_i | input | 1 | Embedded controller acknowledges a retraction |
| soft_rst_ok_i | input | 1 | Soft reset is permitted |
| irq_o | output | 1 | Masked interrupt line |

## Verification
The bench aims at the ownership edges. Domain 0 must refuse delegation; a design that let it through would show the delegated flag set in status. A delegated domain must refuse power commands; getting this wrong would show a changed ready mask. A retraction must wait for the yield pin; a design that completed early would drop retract pending before ec_yield_i was raised. The bench also checks masks that touch absent cores and masks that ask for no change, where a wrong design would raise spurious interrupts or phantom ready bits. With two domains in flight at once, a design that raised the all-changed interrupt on the first completion would fail.

// File: rtl/pwr_domain_pkg.sv
`timescale 1ns/1ps
package pwr_domain_pkg;

    typedef enum logic [3:0] {
        OP_UP      = 4'd1,
        OP_DOWN    = 4'd2,
        OP_DELEG   = 4'd3,
        OP_RETRACT = 4'd4,
        OP_SRST    = 4'd5,
        OP_INSPECT = 4'd6
    } pwr_op_e;

    typedef struct packed {
        logic [3:0] dom;
        pwr_op_e    op;
    } pwr_cmd_t;

    localparam int IRQ_W      = 8;
    localparam int IRQ_ONE    = 0;
    localparam int IRQ_ALL    = 1;
    localparam int IRQ_DELEG  = 2;
    localparam int IRQ_RST    = 3;
    localparam int IRQ_RETR   = 4;
    localparam int IRQ_INSP   = 5;
    localparam int IRQ_NALLOW = 6;
    localparam int IRQ_INVAL  = 7;

    localparam int A_ARG      = 0;
    localparam int A_CMD      = 1;
    localparam int A_STATUS   = 2;
    localparam int A_RAW      = 3;
    localparam int A_CLR      = 4;
    localparam int A_MASK     = 5;
    localparam int A_DOM_BASE = 16;
    localparam int DOM_STRIDE = 4;

    localparam int ST_ALLOW_LSB = 0;
    localparam int ST_DELEG_LSB = 8;
    localparam int ST_RPEND     = 16;
    localparam int ST_SRST_OK   = 17;
    localparam int ST_RST_BUSY  = 18;

endpackage

// File: rtl/pwr_core_seq.sv
`timescale 1ns/1ps
module pwr_core_seq #(
    parameter int CORES     = 8,
    parameter int TRANS_CYC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CORES-1:0] present_i,
    input  logic             start_i,
    input  logic             up_i,
    input  logic [CORES-1:0] mask_i,
    input  logic             wipe_i,
    output logic [CORES-1:0] ready_o,
    output logic [CORES-1:0] trans_o,
    output logic             done_o
);
    localparam int CNT_W = $clog2(TRANS_CYC + 1);

    typedef struct packed {
        logic [CORES-1:0] ready;
        logic [CORES-1:0] trans;
        logic             up;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_q, s_d;
    logic [CORES-1:0] chg;
    logic fin;

    always_comb begin
        s_d = s_q;
        fin = (s_q.trans != '0) && (s_q.cnt == CNT_W'(1));
        chg = up_i ? (mask_i & present_i & ~s_q.ready)
                   : (mask_i & present_i & s_q.ready);
        if (wipe_i) begin
            s_d = '0;
        end else if (s_q.trans != '0) begin
            if (fin) begin
                s_d.ready = s_q.up ? (s_q.ready | s_q.trans) : (s_q.ready & ~s_q.trans);
                s_d.trans = '0;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end else if (start_i && (chg != '0)) begin
            s_d.trans = chg;
            s_d.up    = up_i;
            s_d.cnt   = CNT_W'(TRANS_CYC);
        end
        s_d.ready = s_d.ready & present_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ready_o = s_q.ready;
    assign trans_o = s_q.trans;
    assign done_o  = fin && !wipe_i;

    p_up_sets_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin && s_q.up && !wipe_i) |=> ((s_q.ready & $past(s_q.trans)) == $past(s_q.trans)));

    p_down_clears_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin && !s_q.up && !wipe_i) |=> ((s_q.ready & $past(s_q.trans)) == '0));

    p_trans_in_present_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.trans & ~present_i) == '0));

    p_trans_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((s_q.trans != '0) && !fin && !wipe_i) |=> $stable(s_q.trans));

endmodule

// File: rtl/pwr_cmd_ctrl.sv
`timescale 1ns/1ps
module pwr_cmd_ctrl
    import pwr_domain_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int RST_CYC = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cmd_vld_i,
    input  pwr_cmd_t             cmd_i,
    input  logic [NUM_DOM-1:0]   busy_i,
    input  logic                 ec_yield_i,
    input  logic                 srst_ok_i,
    output logic [NUM_DOM-1:0]   start_o,
    output logic                 up_o,
    output logic                 wipe_o,
    output logic [NUM_DOM-1:0]   allowed_o,
    output logic [NUM_DOM-1:0]   deleg_o,
    output logic                 rpend_o,
    output logic                 rst_busy_o,
    output logic [IRQ_W-1:0]     ev_o
);
    localparam int DI_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
    localparam int RC_W = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic [NUM_DOM-1:0] deleg;
        logic               rpend;
        logic [DI_W-1:0]    rdom;
        logic               rst_busy;
        logic [RC_W-1:0]    rst_cnt;
    } ctl_t;

    ctl_t s_q, s_d;
    logic dom_ok, is_l2;
    logic [DI_W-1:0] di;

    always_comb begin
        s_d     = s_q;
        start_o = '0;
        ev_o    = '0;
        up_o    = (cmd_i.op == OP_UP);
        wipe_o  = s_q.rst_busy && (s_q.rst_cnt == RC_W'(1));
        dom_ok  = int'(cmd_i.dom) < NUM_DOM;
        is_l2   = (cmd_i.dom == 4'd0);
        di      = cmd_i.dom[DI_W-1:0];

        if (s_q.rst_busy) begin
            if (wipe_o) begin
                s_d.rst_busy = 1'b0;
                s_d.rst_cnt  = '0;
                s_d.deleg    = '0;
                s_d.rpend    = 1'b0;
                ev_o[IRQ_RST] = 1'b1;
            end else begin
                s_d.rst_cnt = s_q.rst_cnt - RC_W'(1);
            end
        end

        if (s_q.rpend && ec_yield_i) begin
            s_d.deleg[s_q.rdom] = 1'b0;
            s_d.rpend           = 1'b0;
            ev_o[IRQ_RETR]      = 1'b1;
            ev_o[IRQ_DELEG]     = 1'b1;
        end

        if (cmd_vld_i) begin
            case (cmd_i.op)
                OP_UP, OP_DOWN: begin
                    if (!dom_ok) ev_o[IRQ_INVAL] = 1'b1;
                    else if (s_q.rst_busy || s_q.deleg[di] || busy_i[di]) ev_o[IRQ_NALLOW] = 1'b1;
                    else start_o[di] = 1'b1;
                end
                OP_DELEG: begin
                    if (!dom_ok) ev_o[IRQ_INVAL] = 1'b1;
                    else if (is_l2 || s_q.rst_busy || s_q.deleg[di] || busy_i[di])
                        ev_o[IRQ_NALLOW] = 1'b1;
                    else begin
                        s_d.deleg[di]   = 1'b1;
                        ev_o[IRQ_DELEG] = 1'b1;
                    end
                end
                OP_RETRACT: begin
                    if (!dom_ok) ev_o[IRQ_INVAL] = 1'b1;
                    else if (is_l2 || s_q.rst_busy || !s_q.deleg[di] || s_q.rpend)
                        ev_o[IRQ_NALLOW] = 1'b1;
                    else begin
                        s_d.rpend = 1'b1;
                        s_d.rdom  = di;
                    end
                end
                OP_SRST: begin
                    if (s_q.rst_busy || !srst_ok_i || s_q.rpend) ev_o[IRQ_NALLOW] = 1'b1;
                    else begin
                        s_d.rst_busy = 1'b1;
                        s_d.rst_cnt  = RC_W'(RST_CYC);
                    end
                end
                OP_INSPECT: begin
                    if (!dom_ok) ev_o[IRQ_INVAL] = 1'b1;
                    else if (s_q.rst_busy) ev_o[IRQ_NALLOW] = 1'b1;
                    else ev_o[IRQ_INSP] = 1'b1;
                end
                default: ev_o[IRQ_INVAL] = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign allowed_o  = ~s_q.deleg;
    assign deleg_o    = s_q.deleg;
    assign rpend_o    = s_q.rpend;
    assign rst_busy_o = s_q.rst_busy;

    p_l2_refused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && ((cmd_i.op == OP_DELEG) || (cmd_i.op == OP_RETRACT)) && is_l2)
        |-> ev_o[IRQ_NALLOW]);

    p_l2_never_delegated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.deleg[0]);

    p_rpend_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.rpend && !ec_yield_i) |=> s_q.rpend);

    p_srst_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && (cmd_i.op == OP_SRST) && !srst_ok_i && !s_q.rst_busy) |=> !s_q.rst_busy);

    p_deleg_blocks_power_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_vld_i && dom_ok && s_q.deleg[di]) |-> (start_o == '0));

    p_single_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(start_o));

endmodule

// File: rtl/pwr_irq_unit.sv
`timescale 1ns/1ps
module pwr_irq_unit
    import pwr_domain_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IRQ_W-1:0] ev_i,
    input  logic             any_busy_i,
    input  logic             clr_wr_i,
    input  logic             mask_wr_i,
    input  logic [IRQ_W-1:0] wdata_i,
    output logic [IRQ_W-1:0] raw_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic [IRQ_W-1:0] mask;
        logic             busy_prev;
    } irq_t;

    irq_t s_q, s_d;
    logic [IRQ_W-1:0] ev_full;

    always_comb begin
        s_d = s_q;
        ev_full = ev_i;
        ev_full[IRQ_ALL] = ev_i[IRQ_ALL] | (s_q.busy_prev & ~any_busy_i);
        if (clr_wr_i)  s_d.raw  = s_q.raw & ~wdata_i;
        s_d.raw = s_d.raw | ev_full;
        if (mask_wr_i) s_d.mask = wdata_i;
        s_d.busy_prev = any_busy_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign raw_o  = s_q.raw;
    assign mask_o = s_q.mask;
    assign irq_o  = |(s_q.raw & s_q.mask);

    p_clear_bits_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr_i |=> ((s_q.raw & $past(wdata_i & ~ev_full)) == '0));

    p_raw_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_wr_i |=> ((s_q.raw & $past(s_q.raw)) == $past(s_q.raw)));

    p_all_changed_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.raw[IRQ_ALL]) |-> $past(!any_busy_i));

endmodule

// File: rtl/pwr_domain_ctrl.sv
`timescale 1ns/1ps
module pwr_domain_ctrl
    import pwr_domain_pkg::*;
#(
    parameter int NUM_DOM   = 4,
    parameter int CORES     = 8,
    parameter int TRANS_CYC = 4,
    parameter int RST_CYC   = 6,
    parameter int ADDR_W    = 6
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       reg_wr_i,
    input  logic [ADDR_W-1:0]          reg_addr_i,
    input  logic [63:0]                reg_wdata_i,
    output logic [63:0]                reg_rdata_o,
    input  logic [NUM_DOM*CORES-1:0]   present_i,
    input  logic                       ec_yield_i,
    input  logic                       soft_rst_ok_i,
    output logic                       irq_o
);
    typedef struct packed {
        logic [63:0] arg;
    } top_t;

    top_t s_q, s_d;

    logic [NUM_DOM-1:0][CORES-1:0] ready_w, trans_w;
    logic [NUM_DOM-1:0] busy_w, done_w, start_w, allowed_w, deleg_w;
    logic up_w, wipe_w, rpend_w, rst_busy_w, cmd_vld;
    logic [IRQ_W-1:0] ctl_ev, ev_all, raw_w, mask_w;
    pwr_cmd_t cmd;

    assign cmd_vld = reg_wr_i && (reg_addr_i == ADDR_W'(A_CMD));
    assign cmd     = pwr_cmd_t'(reg_wdata_i[7:0]);

    always_comb begin
        s_d = s_q;
        if (reg_wr_i && (reg_addr_i == ADDR_W'(A_ARG))) s_d.arg = reg_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pwr_core_seq #(.CORES(CORES), .TRANS_CYC(TRANS_CYC)) u_seq (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .present_i (present_i[d*CORES +: CORES]),
            .start_i   (start_w[d]),
            .up_i      (up_w),
            .mask_i    (s_q.arg[CORES-1:0]),
            .wipe_i    (wipe_w),
            .ready_o   (ready_w[d]),
            .trans_o   (trans_w[d]),
            .done_o    (done_w[d])
        );
        assign busy_w[d] = (trans_w[d] != '0);
    end

    pwr_cmd_ctrl #(.NUM_DOM(NUM_DOM), .RST_CYC(RST_CYC)) u_ctl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cmd_vld_i  (cmd_vld),
        .cmd_i      (cmd),
        .busy_i     (busy_w),
        .ec_yield_i (ec_yield_i),
        .srst_ok_i  (soft_rst_ok_i),
        .start_o    (start_w),
        .up_o       (up_w),
        .wipe_o     (wipe_w),
        .allowed_o  (allowed_w),
        .deleg_o    (deleg_w),
        .rpend_o    (rpend_w),
        .rst_busy_o (rst_busy_w),
        .ev_o       (ctl_ev)
    );

    always_comb begin
        ev_all = ctl_ev;
        ev_all[IRQ_ONE] = ctl_ev[IRQ_ONE] | (|done_w);
    end

    pwr_irq_unit u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ev_i       (ev_all),
        .any_busy_i (|busy_w),
        .clr_wr_i   (reg_wr_i && (reg_addr_i == ADDR_W'(A_CLR))),
        .mask_wr_i  (reg_wr_i && (reg_addr_i == ADDR_W'(A_MASK))),
        .wdata_i    (reg_wdata_i[IRQ_W-1:0]),
        .raw_o      (raw_w),
        .mask_o     (mask_w),
        .irq_o      (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(A_ARG)) begin
            reg_rdata_o = s_q.arg;
        end else if (reg_addr_i == ADDR_W'(A_STATUS)) begin
            reg_rdata_o[ST_ALLOW_LSB +: NUM_DOM] = allowed_w;
            reg_rdata_o[ST_DELEG_LSB +: NUM_DOM] = deleg_w;
            reg_rdata_o[ST_RPEND]    = rpend_w;
            reg_rdata_o[ST_SRST_OK]  = soft_rst_ok_i;
            reg_rdata_o[ST_RST_BUSY] = rst_busy_w;
        end else if (reg_addr_i == ADDR_W'(A_RAW)) begin
            reg_rdata_o[IRQ_W-1:0] = raw_w;
        end else if (reg_addr_i == ADDR_W'(A_MASK)) begin
            reg_rdata_o[IRQ_W-1:0] = mask_w;
        end
        for (int d = 0; d < NUM_DOM; d++) begin
            if (reg_addr_i == ADDR_W'(A_DOM_BASE + DOM_STRIDE*d))
                reg_rdata_o[CORES-1:0] = present_i[d*CORES +: CORES];
            if (reg_addr_i == ADDR_W'(A_DOM_BASE + DOM_STRIDE*d + 1))
                reg_rdata_o[CORES-1:0] = ready_w[d];
            if (reg_addr_i == ADDR_W'(A_DOM_BASE + DOM_STRIDE*d + 2))
                reg_rdata_o[CORES-1:0] = trans_w[d];
        end
    end

endmodule

// File: tb/pwr_domain_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_domain_ctrl_tb_top;
    localparam int ND = 4;
    localparam int NC = 8;
    localparam int TC = 4;
    localparam int RC = 6;
    localparam int AW = 6;
    localparam logic [ND*NC-1:0] PRES = {8'h01, 8'hF3, 8'h0F, 8'hFF};

    localparam int A_ARG = 0, A_CMD = 1, A_ST = 2, A_RAW = 3, A_CLR = 4, A_MSK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic ec_yield = 1'b0;
    logic srst_ok = 1'b0;
    logic irq;

    int checks = 0;
    int fails = 0;
    logic [NC-1:0] ready_m [ND];

    always #2.5 clk = ~clk;

    pwr_domain_ctrl #(.NUM_DOM(ND), .CORES(NC), .TRANS_CYC(TC), .RST_CYC(RC), .ADDR_W(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .present_i(PRES),
        .ec_yield_i(ec_yield), .soft_rst_ok_i(srst_ok), .irq_o(irq)
    );

    function automatic logic [NC-1:0] pres_of(int d);
        return PRES[d*NC +: NC];
    endfunction

    function automatic logic [NC-1:0] chg_fn(logic up, logic [NC-1:0] m, logic [NC-1:0] p, logic [NC-1:0] r);
        return up ? (m & p & ~r) : (m & p & r);
    endfunction

    function automatic logic [63:0] status_fn(logic [ND-1:0] dl, logic rp, logic ok, logic rb);
        logic [63:0] s = '0;
        s[ND-1:0]  = ~dl;
        s[8 +: ND] = dl;
        s[16] = rp;
        s[17] = ok;
        s[18] = rb;
        return s;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(int a, logic [63:0] d);
        @(negedge clk);
        wr = 1'b1; addr = AW'(a); wdata = d;
        @(posedge clk);
        #1 wr = 1'b0;
    endtask

    task automatic rd_reg(int a, output logic [63:0] d);
        @(negedge clk);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic send(logic [3:0] op, logic [3:0] dom);
        wr_reg(A_CMD, {56'd0, dom, op});
    endtask

    task automatic clr_raw();
        wr_reg(A_CLR, 64'hFF);
    endtask

    task automatic power(int d, logic up, logic [NC-1:0] m, string req);
        logic [63:0] v;
        logic [NC-1:0] c, e;
        c = chg_fn(up, m, pres_of(d), ready_m[d]);
        e = up ? (ready_m[d] | c) : (ready_m[d] & ~c);
        clr_raw();
        wr_reg(A_ARG, {56'd0, m});
        send(up ? 4'd1 : 4'd2, 4'(d));
        rd_reg(16 + 4*d + 2, v);
        check({req, " R4 trans during"}, v, {56'd0, c});
        repeat (TC + 1) @(posedge clk);
        rd_reg(16 + 4*d + 1, v);
        check({req, " ready"}, v, {56'd0, e});
        rd_reg(16 + 4*d + 2, v);
        check("R4 trans cleared", v, 64'd0);
        rd_reg(A_RAW, v);
        check("R5 change irqs", v, (c != '0) ? 64'h3 : 64'h0);
        ready_m[d] = e;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog (all requirements) got=timeout exp=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'h1F2E3D));
        for (int d = 0; d < ND; d++) ready_m[d] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        rd_reg(A_ST, v);   check("R1 status after reset", v, status_fn(4'b0000, 0, 0, 0));
        rd_reg(A_RAW, v);  check("R1 raw after reset", v, 64'd0);
        rd_reg(17, v);     check("R1 ready after reset", v, 64'd0);
        rd_reg(A_DOM_FIX(2), v); check("R1 present readback", v, {56'd0, pres_of(2)});
        check("R1 irq line after reset", {63'd0, irq}, 64'd0);

        // R2: exact timing of power up on domain 0
        wr_reg(A_ARG, 64'hFF);
        send(4'd1, 4'd0);
        repeat (TC - 1) @(posedge clk);
        rd_reg(17, v); check("R2 ready not early", v, 64'd0);
        @(posedge clk);
        rd_reg(17, v); check("R2 ready at TRANS_CYC", v, 64'hFF);
        ready_m[0] = 8'hFF;

        power(1, 1'b1, 8'hFF, "R4 absent cores masked");
        power(0, 1'b0, 8'h0F, "R3 power down");
        power(0, 1'b0, 8'h0F, "R5 no-change command");

        // R5: two domains in flight
        clr_raw();
        wr_reg(A_ARG, 64'h03);
        send(4'd1, 4'd0);
        send(4'd2, 4'd1);
        repeat (4) @(posedge clk);
        rd_reg(A_RAW, v); check("R5 single without all", v, 64'h1);
        @(posedge clk);
        rd_reg(A_RAW, v); check("R5 all after last domain", v, 64'h3);
        ready_m[0] = 8'hF3; ready_m[1] = 8'h0C;

        // R6 delegate domain 2
        clr_raw();
        send(4'd3, 4'd2);
        rd_reg(A_ST, v);  check("R6 delegated flags", v, status_fn(4'b0100, 0, 0, 0));
        rd_reg(A_RAW, v); check("R6 delegation irq", v, 64'h04);

        // R9 power on delegated domain refused
        clr_raw();
        wr_reg(A_ARG, 64'hFF);
        send(4'd1, 4'd2);
        repeat (TC + 1) @(posedge clk);
        rd_reg(18, v);    check("R9 delegated domain ready unchanged", {56'd0, 8'(rdata)} | (v & 0), 64'd0);
        rd_reg(16+4*2+1, v); check("R9 delegated ready", v, 64'd0);
        rd_reg(A_RAW, v); check("R9 not-allowed irq", v, 64'h40);

        // R9 domain in transition refused
        clr_raw();
        wr_reg(A_ARG, 64'h01);
        send(4'd1, 4'd3);
        send(4'd2, 4'd3);
        repeat (TC + 1) @(posedge clk);
        rd_reg(16+4*3+1, v); check("R9 busy domain keeps first result", v, 64'h01);
        rd_reg(A_RAW, v);    check("R9 busy refusal irq", v, 64'h43);
        ready_m[3] = 8'h01;

        // R8 L2 delegate/retract refused
        clr_raw();
        send(4'd3, 4'd0);
        send(4'd4, 4'd0);
        rd_reg(A_ST, v);  check("R8 L2 flags unchanged", v, status_fn(4'b0100, 0, 0, 0));
        rd_reg(A_RAW, v); check("R8 not-allowed irq", v, 64'h40);

        // R7 retract waits for yield
        clr_raw();
        send(4'd4, 4'd2);
        rd_reg(A_ST, v); check("R7 retract pending", v, status_fn(4'b0100, 1, 0, 0));
        repeat (5) @(posedge clk);
        rd_reg(A_ST, v); check("R7 pending held without yield", v, status_fn(4'b0100, 1, 0, 0));
        rd_reg(A_RAW, v); check("R7 no completion yet", v, 64'h0);
        @(negedge clk) ec_yield = 1'b1;
        @(posedge clk);
        #1 ec_yield = 1'b0;
        rd_reg(A_ST, v);  check("R7 returned to host", v, status_fn(4'b0000, 0, 0, 0));
        rd_reg(A_RAW, v); check("R7 retract irqs", v, 64'h14);

        // R10 invalid
        clr_raw();
        send(4'd1, 4'd9);
        rd_reg(A_RAW, v); check("R10 bad domain", v, 64'h80);
        clr_raw();
        send(4'd15, 4'd1);
        rd_reg(A_RAW, v); check("R10 bad opcode", v, 64'h80);
        rd_reg(16+4*1+2, v); check("R10 no transition started", v, 64'd0);

        // R12 inspect
        clr_raw();
        send(4'd6, 4'd1);
        rd_reg(A_RAW, v); check("R12 inspect irq", v, 64'h20);

        // R13 mask and line
        clr_raw();
        wr_reg(A_MSK, 64'h40);
        send(4'd5, 4'd0);
        rd_reg(A_RAW, v); check("R11 soft reset refused", v, 64'h40);
        check("R13 irq line high", {63'd0, irq}, 64'd1);
        wr_reg(A_CLR, 64'h40);
        rd_reg(A_RAW, v); check("R13 cleared raw", v, 64'd0);
        check("R13 irq line low", {63'd0, irq}, 64'd0);
        wr_reg(A_MSK, 64'h00);

        // random power traffic
        for (int i = 0; i < 30; i++) begin
            int d;
            logic up;
            logic [NC-1:0] m;
            d  = int'($urandom_range(0, ND - 1));
            up = 1'($urandom_range(0, 1));
            m  = NC'($urandom);
            power(d, up, m, up ? "R2 random up" : "R3 random down");
        end

        // R11 soft reset
        send(4'd3, 4'd3);
        srst_ok = 1'b1;
        clr_raw();
        send(4'd5, 4'd0);
        rd_reg(A_ST, v); check("R11 reset in progress", v, status_fn(4'b1000, 0, 1, 1));
        repeat (RC + 1) @(posedge clk);
        rd_reg(A_ST, v); check("R11 delegations dropped", v, status_fn(4'b0000, 0, 1, 0));
        for (int d = 0; d < ND; d++) begin
            rd_reg(16 + 4*d + 1, v); check("R11 ready cleared", v, 64'd0);
        end
        rd_reg(A_RAW, v); check("R11 reset completed irq", v, 64'h08);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic int A_DOM_FIX(int d);
        return 16 + 4*d;
    endfunction

endmodule